// File: doc/BRIEF.md
# SATA Adapter Bring-Up Sequencer

This block brings one of two SATA adapters online without software stepping through the sequence. A start request selects adapter 0 or 1. The block then does the following in order:

1. It turns on that adapter's peripheral clock.
2. It lets the clock settle for a programmable number of millisecond ticks.
3. It issues a single write of the adapter control word to the adapter's control register offset.
4. It waits a further settle interval.
5. It samples the PHY ready flag in the status word at a fixed poll interval.

If ready is seen within the poll budget, the block pulses done with the result set to ok and leaves the clock running. If the budget runs out first, it turns the adapter's clock off again and pulses done with the result set to not ok.

The control word depends on the routing mode, which decides whether an adapter acts as a slave device on its parallel ATA channel. Millisecond delays are counted on an external tick, so the same logic serves at any clock rate. The interval lengths are parameters, so a bench can shorten them. A stop request turns off an adapter's clock at once and abandons any sequence in progress.

Top module: `sata_link_bringup`

## Requirements
- R1: After reset, both clock-enable bits, the done pulse, the ok result and the control-write strobe are all 0.
- R2: A start in idle sets `clk_en_o[sel_i]` on the next cycle. That bit stays set through the control write, which is issued after SETTLE_MS millisecond ticks.
- R3: The 16-bit control word always has bit 4 (hot-plug detect) and bit 0 (adapter enable) set. Bit 1 (slave) is set only for adapter 0 with route mode 2, or for adapter 1 with route mode 3. Every other bit, including bits 2, 3, 9, 10, 12, 13 and 14, is 0.
- R4: The control write goes to offset 0x18 for adapter 0 and to offset 0x1C for adapter 1. It is exactly one cycle of `ctrl_wr_o` per sequence.
- R5: After the write, the block waits SETTLE_MS ticks and then samples the status word every POLL_MS ticks. Only bit 0 (PHY ready) matters; all other status bits are ignored.
- R6: When ready is sampled as 1, done pulses with ok=1 after exactly SETTLE_MS + k·POLL_MS ticks from the write, where k is the index of the successful sample. The adapter clock stays on.
- R7: When BUDGET_MS/POLL_MS samples all read 0, done pulses with ok=0 and the selected adapter's clock-enable bit is cleared.
- R8: Done is high for exactly one cycle. Ok holds its value until the next accepted start, which clears it.
- R9: A start that arrives while a sequence is running is ignored: there is no second write, and the other adapter's clock is untouched.
- R10: A stop clears the clock-enable bit of the adapter in use on the next cycle, or of `sel_i` when the block is idle. It returns the block to idle with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a bring-up sequence |
| stop_i | input | 1 | Abort and gate the adapter clock off |
| sel_i | input | 1 | Adapter select, 0 or 1 |
| route_mode_i | input | 3 | Current routing mode |
| phy_status_i | input | 32 | Status word of the selected adapter |
| ms_tick_i | input | 1 | One-cycle pulse per millisecond |
| clk_en_o | output | 2 | Peripheral clock enables, bit n for adapter n |
| ctrl_wr_o | output | 1 | Control-register write strobe |
| ctrl_addr_o | output | 8 | Control-register offset |
| ctrl_word_o | output | 16 | Control word |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Result of the last sequence, 1 = online |

## Verification
The bench covers each mode and adapter pairing that flips the slave bit. A generator that ignores the adapter index would set slave for both adapters in mode 2, and the bench would report the wrong word.

The bench raises ready only on the last permitted sample, so an off-by-one in the poll counter turns that success into a timeout. In the timeout case the bench sets every status bit except bit 0; a design that tests the whole word would then report success.

The bench issues a stop in the middle of polling, and a start while busy, and watches for any stray done pulse, extra write or clock-enable change that a design not handling these would produce.

// File: rtl/sata_bringup_pkg.sv
package sata_bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLKWAIT,
    ST_WRITE,
    ST_SETTLE,
    ST_POLL
  } bring_state_e;

  localparam int unsigned CW_ENABLE_BIT = 0;
  localparam int unsigned CW_SLAVE_BIT  = 1;
  localparam int unsigned CW_HPDET_BIT  = 4;
  localparam int unsigned READY_BIT     = 0;

  localparam logic [2:0] MODE_A0_SLAVE = 3'd2;
  localparam logic [2:0] MODE_A1_SLAVE = 3'd3;

  localparam logic [7:0] CTRL_OFS_A0 = 8'h18;
  localparam logic [7:0] CTRL_OFS_A1 = 8'h1C;

endpackage

// File: rtl/ms_wait_timer.sv
module ms_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_en;

  assign dec_en = tick_i && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (dec_en) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load_i || dec_en)  cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R5: arming with a nonzero interval must hold off expiry for at least one cycle
  assert_load_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (load_val_i != '0)) |=> !expired_o);

endmodule

// File: rtl/ctrl_word_map.sv
module ctrl_word_map
  import sata_bringup_pkg::*;
#(
  parameter int unsigned CTRL_W = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              sel_i,
  input  logic [2:0]        mode_i,
  output logic [CTRL_W-1:0] word_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic slave_a0, slave_a1;

  assign slave_a0 = !sel_i && (mode_i == MODE_A0_SLAVE);
  assign slave_a1 =  sel_i && (mode_i == MODE_A1_SLAVE);

  always_comb begin
    word_o                = '0;
    word_o[CW_ENABLE_BIT] = 1'b1;
    word_o[CW_HPDET_BIT]  = 1'b1;
    word_o[CW_SLAVE_BIT]  = slave_a0 || slave_a1;
  end

  assign addr_o = sel_i ? ADDR_W'(CTRL_OFS_A1) : ADDR_W'(CTRL_OFS_A0);

endmodule

// File: rtl/sata_link_bringup.sv
module sata_link_bringup
  import sata_bringup_pkg::*;
#(
  parameter int unsigned SETTLE_MS = 10,
  parameter int unsigned POLL_MS   = 100,
  parameter int unsigned BUDGET_MS = 1000,
  parameter int unsigned STAT_W    = 32,
  parameter int unsigned CTRL_W    = 16,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sel_i,
  input  logic [2:0]        route_mode_i,
  input  logic [STAT_W-1:0] phy_status_i,
  input  logic              ms_tick_i,
  output logic [1:0]        clk_en_o,
  output logic              ctrl_wr_o,
  output logic [ADDR_W-1:0] ctrl_addr_o,
  output logic [CTRL_W-1:0] ctrl_word_o,
  output logic              done_o,
  output logic              ok_o
);

  localparam int unsigned TMR_MAX   = (SETTLE_MS > POLL_MS) ? SETTLE_MS : POLL_MS;
  localparam int unsigned CNT_W     = $clog2(TMR_MAX + 1);
  localparam int unsigned MAX_POLLS = (BUDGET_MS / POLL_MS > 0) ? BUDGET_MS / POLL_MS : 1;
  localparam int unsigned POLL_W    = $clog2(MAX_POLLS + 1);

  // asynchronous assert, synchronous release
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  bring_state_e      state_q, state_d;
  logic              sel_q, sel_d;
  logic [2:0]        mode_q, mode_d;
  logic [1:0]        clk_en_q, clk_en_d;
  logic [POLL_W-1:0] polls_q, polls_d;
  logic              done_q, done_d;
  logic              ok_q, ok_d;
  logic              tmr_load;
  logic [CNT_W-1:0]  tmr_val;
  logic              tmr_expired;
  logic              busy, stop_tgt, phy_ready;

  assign busy      = (state_q != ST_IDLE);
  assign stop_tgt  = busy ? sel_q : sel_i;
  assign phy_ready = phy_status_i[READY_BIT];

  ms_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (ms_tick_i),
    .expired_o  (tmr_expired)
  );

  ctrl_word_map #(.CTRL_W(CTRL_W), .ADDR_W(ADDR_W)) u_map (
    .sel_i  (sel_q),
    .mode_i (mode_q),
    .word_o (ctrl_word_o),
    .addr_o (ctrl_addr_o)
  );

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    mode_d   = mode_q;
    clk_en_d = clk_en_q;
    polls_d  = polls_q;
    done_d   = 1'b0;
    ok_d     = ok_q;
    tmr_load = 1'b0;
    tmr_val  = CNT_W'(SETTLE_MS);
    if (stop_i) begin
      clk_en_d[stop_tgt] = 1'b0;
      state_d            = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          sel_d           = sel_i;
          mode_d          = route_mode_i;
          clk_en_d[sel_i] = 1'b1;
          ok_d            = 1'b0;
          tmr_load        = 1'b1;
          state_d         = ST_CLKWAIT;
        end
        ST_CLKWAIT: if (tmr_expired) state_d = ST_WRITE;
        ST_WRITE: begin
          tmr_load = 1'b1;
          state_d  = ST_SETTLE;
        end
        ST_SETTLE: if (tmr_expired) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(POLL_MS);
          polls_d  = '0;
          state_d  = ST_POLL;
        end
        ST_POLL: if (tmr_expired) begin
          if (phy_ready) begin
            done_d  = 1'b1;
            ok_d    = 1'b1;
            state_d = ST_IDLE;
          end else if (polls_q == POLL_W'(MAX_POLLS - 1)) begin
            done_d          = 1'b1;
            ok_d            = 1'b0;
            clk_en_d[sel_q] = 1'b0;
            state_d         = ST_IDLE;
          end else begin
            polls_d  = polls_q + 1'b1;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(POLL_MS);
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      sel_q    <= 1'b0;
      mode_q   <= '0;
      clk_en_q <= '0;
      polls_q  <= '0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      sel_q    <= sel_d;
      mode_q   <= mode_d;
      clk_en_q <= clk_en_d;
      polls_q  <= polls_d;
      done_q   <= done_d;
      ok_q     <= ok_d;
    end
  end

  assign clk_en_o  = clk_en_q;
  assign ctrl_wr_o = (state_q == ST_WRITE);
  assign done_o    = done_q;
  assign ok_o      = ok_q;

  assert_write_clocked_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr_o |-> clk_en_o[sel_q]);

  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    ctrl_wr_o |=> !ctrl_wr_o);

  assert_ok_keeps_clock_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && ok_o) |-> clk_en_o[sel_q]);

  assert_fail_gates_clock_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_o && !ok_o) |-> !clk_en_o[sel_q]);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_busy_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && start_i && !stop_i) |=> ($stable(sel_q) && $stable(mode_q)));

  assert_stop_gates_clock_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    stop_i |=> (!clk_en_o[$past(stop_tgt)] && !done_o));

endmodule

// File: tb/sata_link_bringup_bench.sv
module sata_link_bringup_bench;

  localparam int SETTLE = 2;
  localparam int POLL   = 3;
  localparam int BUDGET = 12;
  localparam int NPOLL  = BUDGET / POLL;

  typedef struct {
    logic [7:0]  addr;
    logic [15:0] word;
    logic        ok;
    int          ticks;
    bit          abort;
  } exp_t;

  logic        clk, rst_n, start_i, stop_i, sel_i, ms_tick_i;
  logic [2:0]  route_mode_i;
  logic [31:0] phy_status_i;
  logic [1:0]  clk_en_o;
  logic        ctrl_wr_o, done_o, ok_o;
  logic [7:0]  ctrl_addr_o;
  logic [15:0] ctrl_word_o;

  int   checks = 0, failures = 0;
  bit   finished = 0;
  exp_t exp_q[$];

  sata_link_bringup #(.SETTLE_MS(SETTLE), .POLL_MS(POLL), .BUDGET_MS(BUDGET)) u_sata_link_bringup (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .sel_i(sel_i),
    .route_mode_i(route_mode_i), .phy_status_i(phy_status_i), .ms_tick_i(ms_tick_i),
    .clk_en_o(clk_en_o), .ctrl_wr_o(ctrl_wr_o), .ctrl_addr_o(ctrl_addr_o),
    .ctrl_word_o(ctrl_word_o), .done_o(done_o), .ok_o(ok_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit cond, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // millisecond tick, one pulse every 4 cycles
  initial begin
    ms_tick_i = 1'b0;
    wait (rst_n);
    forever begin
      @(negedge clk) ms_tick_i = 1'b1;
      @(negedge clk) ms_tick_i = 1'b0;
      repeat (2) @(negedge clk);
    end
  end

  // monitor: pops expected items and compares
  initial begin
    exp_t cur;
    bit   in_seq = 0, prev_done = 0;
    int   tick_cnt = 0;
    forever begin
      step();
      if (ctrl_wr_o) begin
        if (exp_q.size() == 0) chk(0, "R9", "unexpected write", ctrl_addr_o, 0);
        else begin
          cur = exp_q[0];
          chk(ctrl_addr_o == cur.addr, "R4", "control offset", ctrl_addr_o, cur.addr);
          chk(ctrl_word_o == cur.word, "R3", "control word", ctrl_word_o, cur.word);
          tick_cnt = 0;
          in_seq   = 1;
          if (cur.abort) begin
            void'(exp_q.pop_front());
            in_seq = 0;
          end
        end
      end else if (ms_tick_i && in_seq) tick_cnt++;
      if (done_o) begin
        if (prev_done) chk(0, "R8", "done wider than one cycle", 1, 0);
        else if (!in_seq || exp_q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
        else begin
          cur = exp_q.pop_front();
          chk(ok_o == cur.ok, cur.ok ? "R6" : "R7", "result", ok_o, cur.ok);
          chk(tick_cnt == cur.ticks, "R5", "ticks from write to done", tick_cnt, cur.ticks);
          in_seq = 0;
        end
      end
      prev_done = done_o;
    end
  end

  // ready_at: sample index that sees ready (0 = never)
  task automatic run_seq(input bit sel, input logic [2:0] mode, input int ready_at,
                         input logic [15:0] exp_word, input bit poke_busy);
    exp_t e;
    bit   exp_ok;
    logic [1:0] clk_before;
    exp_ok     = (ready_at != 0);
    e.addr     = sel ? 8'h1C : 8'h18;
    e.word     = exp_word;
    e.ok       = exp_ok;
    e.ticks    = exp_ok ? SETTLE + POLL * ready_at : SETTLE + POLL * NPOLL;
    e.abort    = 0;
    exp_q.push_back(e);
    clk_before = clk_en_o;
    phy_status_i = (ready_at == 1) ? 32'h1 : 32'hFFFF_FFFE;
    sel_i = sel; route_mode_i = mode; start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk(ok_o == 1'b0, "R8", "ok cleared by start", ok_o, 0);
    chk(clk_en_o[sel] == 1'b1, "R2", "clock enabled on start", clk_en_o, 1);
    while (!ctrl_wr_o) step();
    if (poke_busy) begin
      sel_i = ~sel; route_mode_i = 3'd3; start_i = 1'b1;
      step();
      start_i = 1'b0;
      chk(clk_en_o[~sel] == clk_before[~sel], "R9", "busy start touched other clock",
          clk_en_o, clk_before);
    end
    if (ready_at > 1) begin
      int n = 0;
      while (n < SETTLE + POLL * (ready_at - 1) + 1) begin
        step();
        if (ms_tick_i) n++;
      end
      phy_status_i = 32'h0000_0001;
    end
    while (!done_o) step();
    chk(clk_en_o[sel] == exp_ok, exp_ok ? "R6" : "R7", "clock after done", clk_en_o[sel], exp_ok);
    if (poke_busy)
      chk(clk_en_o[~sel] == clk_before[~sel], "R9", "other clock after done", clk_en_o, clk_before);
    repeat (5) step();
    chk(ok_o == exp_ok, "R8", "result held", ok_o, exp_ok);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; start_i = 0; stop_i = 0; sel_i = 0; route_mode_i = 0; phy_status_i = 0;
    repeat (5) step();
    rst_n = 1'b1;
    repeat (4) step();
    // R1 reset state
    chk(clk_en_o == 2'b00, "R1", "clock enables", clk_en_o, 0);
    chk(done_o == 0 && ok_o == 0 && ctrl_wr_o == 0, "R1", "done/ok/wr",
        {done_o, ok_o, ctrl_wr_o}, 0);

    run_seq(1'b0, 3'd2, 1, 16'h0013, 0);           // slave on adapter 0, ready at once
    run_seq(1'b1, 3'd2, 3, 16'h0011, 0);           // adapter 1 mode 2: no slave
    chk(clk_en_o == 2'b11, "R6", "both clocks running", clk_en_o, 2'b11);
    run_seq(1'b1, 3'd3, 0, 16'h0013, 0);           // timeout with all other bits set
    chk(clk_en_o == 2'b01, "R7", "only adapter 1 gated", clk_en_o, 2'b01);
    run_seq(1'b0, 3'd3, NPOLL, 16'h0011, 0);       // ready on last permitted sample
    run_seq(1'b0, 3'd0, 2, 16'h0011, 1);           // start while busy ignored

    // R10 stop during polling
    begin
      exp_t e;
      e.addr = 8'h1C; e.word = 16'h0011; e.ok = 0; e.ticks = 0; e.abort = 1;
      exp_q.push_back(e);
      phy_status_i = 0; sel_i = 1; route_mode_i = 3'd1; start_i = 1;
      step();
      start_i = 0;
      while (!ctrl_wr_o) step();
      repeat (12) step();
      stop_i = 1;
      step();
      stop_i = 0;
      chk(clk_en_o[1] == 1'b0, "R10", "stop gates clock", clk_en_o, 2'b01);
      repeat (60) step();
      chk(done_o == 0 && clk_en_o == 2'b01, "R10", "no done after stop", clk_en_o, 2'b01);
    end
    run_seq(1'b1, 3'd1, 1, 16'h0011, 0);           // back in idle, accepts start
    // R10 stop while idle gates sel_i
    sel_i = 0; stop_i = 1;
    step();
    stop_i = 0;
    chk(clk_en_o == 2'b10, "R10", "idle stop", clk_en_o, 2'b10);
    chk(exp_q.size() == 0, "R4", "scoreboard drained", exp_q.size(), 0);
    repeat (4) step();
    finish_run();
  end

endmodule